// File: doc/BRIEF.md
# Fractional Clock-Enable Scaler with Committed Rate Updates

This block turns every cycle of its parent clock into an optional enable pulse. Over each fixed window of 32 parent cycles it issues exactly M enables, where M is between 1 and 32, so the enabled logic sees an average rate of parent × M / 32. The enables are spread across the window by an accumulator that swallows the pulses it does not need. The result is as even a pattern as whole cycles allow, not a burst.

Software programs the rate through a small word-addressed register port. The rate field holds 32 − M, so the reset value of zero means full rate. A value written to the field waits in a shadow copy. It changes nothing until software sets the busy/commit flag in a second register. The sequencer then waits for the last cycle of the current window and loads the pending value, so the next window starts with the new rate. It keeps the flag set for one more cycle and then clears it. Software polls the flag and must not start another update while it reads 1.

Top module: `frac_clk_scaler`

## Requirements
- R1: After reset the commit flag reads 0, the rate field reads 0, and `clk_en` is high on every cycle.
- R2: Reads are combinational on `reg_addr`. Word address 0 returns the commit flag at bit 31. Word address 1 returns the pending rate field at bits 12:8. All other bits and all other addresses read 0.
- R3: With an applied field value F, exactly M = 32 − F enables occur in every 32-cycle window, so F = 0 gives an enable on every cycle and F = 31 gives one per window.
- R4: In window phase p (0 to 31), `clk_en` equals floor((p+1)·M/32) − floor(p·M/32).
- R5: A write to the rate field changes its readback on the next cycle but does not change `clk_en` until a commit applies it.
- R6: A write of 1 to bit 31 at address 0 while the flag is clear sets the flag from the cycle after the write.
- R7: A requested value is applied at the end of the window in progress and takes effect at phase 0 of the next window. No window uses two rates.
- R8: The flag stays 1 through the applying edge and for one cycle after it, then clears by itself. No request keeps it set for more than 33 cycles.
- R9: Writes to address 0 while the flag is set are ignored, including writes of 0, so a request cannot be cancelled. Writes to address 0 with bit 31 clear are also ignored.
- R10: The first cycle after reset is window phase 0. Windows follow one another every 32 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 4 | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| clk_en | output | 1 | Scaled clock enable |

## Verification
The scaler is driven through the full range of rates: full rate, one enable per window, half rate, almost full rate and irregular values such as 21 and 27 per window. These show whether the even spread is right for both sparse and dense patterns. Commits are requested at several different phases of the window. This exposes a value that is loaded mid-window or one window late. Field writes with no commit, repeated and zero writes to the flag while it is busy, and writes with stray bits set each show whether a path other than the commit handshake can change the output or the flag.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    // Commit sequencer states
    typedef enum logic [1:0] {
        KS_IDLE   = 2'd0,   // no request outstanding
        KS_ARMED  = 2'd1,   // request taken, waiting for window end
        KS_SETTLE = 2'd2    // value applied, flag held one more cycle
    } kick_state_t;

endpackage

// File: rtl/fcs_regfile.sv
module fcs_regfile #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int FIELD_W    = 5,
    parameter int FIELD_LSB  = 8,
    parameter int KICK_BIT   = 31,
    parameter int ADDR_KICK  = 0,
    parameter int ADDR_SCALE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              kick_busy,
    output logic [DATA_W-1:0] rdata,
    output logic [FIELD_W-1:0] shadow_field,
    output logic              kick_req
);

    localparam logic [ADDR_W-1:0] A_KICK  = ADDR_W'(ADDR_KICK);
    localparam logic [ADDR_W-1:0] A_SCALE = ADDR_W'(ADDR_SCALE);

    logic [FIELD_W-1:0] shadow_q;
    logic               hit_kick;
    logic               hit_scale;
    logic               wdata_unused;

    assign hit_kick     = (addr == A_KICK);
    assign hit_scale    = (addr == A_SCALE);
    assign wdata_unused = ^wdata;

    // pending rate value, kept apart from the applied one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (wr && hit_scale) begin
            shadow_q <= wdata[FIELD_LSB +: FIELD_W];
        end
    end

    // a request is only a write of 1 into the flag position
    assign kick_req     = wr && hit_kick && wdata[KICK_BIT];
    assign shadow_field = shadow_q;

    always_comb begin
        rdata = '0;
        if (hit_kick) begin
            rdata[KICK_BIT] = kick_busy;
        end else if (hit_scale) begin
            rdata[FIELD_LSB +: FIELD_W] = shadow_q;
        end
    end

endmodule

// File: rtl/fcs_kick_fsm.sv
module fcs_kick_fsm
    import fcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic kick_req,
    input  logic window_last,
    output logic kick_busy,
    output logic commit
);

    kick_state_t state_q;
    kick_state_t state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: requests outside IDLE are dropped
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KS_IDLE:   if (kick_req)    state_d = KS_ARMED;
            KS_ARMED:  if (window_last) state_d = KS_SETTLE;
            KS_SETTLE:                  state_d = KS_IDLE;
            default:                    state_d = KS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        kick_busy = 1'b0;
        commit    = 1'b0;
        unique case (state_q)
            KS_IDLE: begin
                kick_busy = 1'b0;
            end
            KS_ARMED: begin
                kick_busy = 1'b1;
                commit    = window_last;
            end
            KS_SETTLE: begin
                kick_busy = 1'b1;
            end
            default: begin
                kick_busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fcs_pulse_gen.sv
module fcs_pulse_gen #(
    parameter int FIELD_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic [FIELD_W-1:0] new_field,
    output logic               clk_en,
    output logic               window_last,
    output logic [FIELD_W-1:0] active_field
);

    localparam int WIN   = 1 << FIELD_W;
    localparam int ACC_W = FIELD_W + 2;
    localparam logic [ACC_W-1:0] WIN_A = ACC_W'(WIN);

    logic [FIELD_W-1:0] phase_q;
    logic [FIELD_W-1:0] act_q;
    logic [FIELD_W-1:0] acc_q;
    logic [ACC_W-1:0]   mult;
    logic [ACC_W-1:0]   sum;
    logic               fire;
    logic [FIELD_W-1:0] acc_d;

    // window position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign window_last = (phase_q == FIELD_W'(WIN - 1));

    // applied rate value, only ever replaced at a window end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (commit && window_last) begin
            act_q <= new_field;
        end
    end

    // pulse swallowing accumulator
    assign mult  = WIN_A - ACC_W'(act_q);
    assign sum   = ACC_W'(acc_q) + mult;
    assign fire  = (sum >= WIN_A);
    assign acc_d = fire ? FIELD_W'(sum - WIN_A) : FIELD_W'(sum);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (window_last) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign clk_en       = fire;
    assign active_field = act_q;

endmodule

// File: rtl/frac_clk_scaler.sv
module frac_clk_scaler #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int FIELD_W    = 5,
    parameter int FIELD_LSB  = 8,
    parameter int KICK_BIT   = 31,
    parameter int ADDR_KICK  = 0,
    parameter int ADDR_SCALE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              clk_en
);

    logic [FIELD_W-1:0] shadow_field;
    logic [FIELD_W-1:0] act_field;
    logic               kick_req;
    logic               kick_busy;
    logic               commit;
    logic               win_last;

    fcs_regfile #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .FIELD_W    (FIELD_W),
        .FIELD_LSB  (FIELD_LSB),
        .KICK_BIT   (KICK_BIT),
        .ADDR_KICK  (ADDR_KICK),
        .ADDR_SCALE (ADDR_SCALE)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (reg_wr),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .kick_busy    (kick_busy),
        .rdata        (reg_rdata),
        .shadow_field (shadow_field),
        .kick_req     (kick_req)
    );

    fcs_kick_fsm u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .kick_req    (kick_req),
        .window_last (win_last),
        .kick_busy   (kick_busy),
        .commit      (commit)
    );

    fcs_pulse_gen #(
        .FIELD_W (FIELD_W)
    ) u_pulse (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit       (commit),
        .new_field    (shadow_field),
        .clk_en       (clk_en),
        .window_last  (win_last),
        .active_field (act_field)
    );

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
    parameter int FIELD_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clk_en,
    input logic               win_last,
    input logic [FIELD_W-1:0] act_field,
    input logic               kick_busy,
    input logic               commit
);

    localparam int WIN = 1 << FIELD_W;

    logic [FIELD_W:0] pulse_cnt;
    logic [FIELD_W:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || win_last) begin
            pulse_cnt <= '0;
        end else begin
            pulse_cnt <= pulse_cnt + (FIELD_W+1)'(clk_en);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !kick_busy) begin
            busy_cnt <= '0;
        end else begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    AST_WINDOW_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
        win_last |-> ((int'(pulse_cnt) + int'(clk_en)) == (WIN - int'(act_field)))); // R3
    AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_field == '0) |-> clk_en); // R1
    AST_HOLD_MIDWINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !win_last |=> $stable(act_field)); // R7
    AST_NO_APPLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !kick_busy |=> $stable(act_field)); // R5
    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        kick_busy |-> (int'(busy_cnt) <= WIN)); // R8
    AST_BUSY_AFTER_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> kick_busy); // R8
    AST_CLEAR_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> ##1 !kick_busy); // R8

endmodule

bind frac_clk_scaler fcs_checker #(.FIELD_W(FIELD_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .win_last  (win_last),
    .act_field (act_field),
    .kick_busy (kick_busy),
    .commit    (commit)
);

// File: tb/test_frac_clk_scaler.sv
`timescale 1ns/1ps
module test_frac_clk_scaler;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        clk_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state
    int m_phase, m_act, m_shadow, m_kst;
    int m_nkst;

    always #5 clk = ~clk;

    frac_clk_scaler i_frac_clk_scaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .clk_en    (clk_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // model: 0 idle, 1 waiting for window end, 2 one cycle after apply
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_act = 0; m_shadow = 0; m_kst = 0;
        end else begin
            m_nkst = m_kst;
            if (m_kst == 0 && reg_wr && reg_addr == 4'd0 && reg_wdata[31]) m_nkst = 1;
            else if (m_kst == 1 && m_phase == 31) begin
                m_nkst = 2;
                m_act  = m_shadow;
            end else if (m_kst == 2) m_nkst = 0;
            m_kst = m_nkst;
            if (reg_wr && reg_addr == 4'd1) m_shadow = int'(reg_wdata[12:8]);
            m_phase = (m_phase + 1) % 32;
        end
    end

    // compare every cycle, mid-period
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            int mm;
            logic exp_en;
            logic [31:0] exp_rd;
            mm     = 32 - m_act;
            exp_en = (((m_phase + 1) * mm) / 32) != ((m_phase * mm) / 32);
            chk("R3 R4 R7 R10 clk_en", {31'b0, clk_en}, {31'b0, exp_en});
            if (reg_addr == 4'd0) begin
                exp_rd = (m_kst != 0) ? 32'h8000_0000 : 32'h0;
                chk("R6 R8 R9 flag readback", reg_rdata, exp_rd);
            end else if (reg_addr == 4'd1) begin
                exp_rd = 32'(m_shadow) << 8;
                chk("R2 R5 field readback", reg_rdata, exp_rd);
            end else begin
                chk("R2 unmapped readback", reg_rdata, 32'h0);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(posedge clk); #2;
        reg_addr = a;
        @(negedge clk); #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // request commit and poll until the flag clears
    task automatic kick_and_wait(input int extra);
        logic [31:0] d;
        int busy;
        wr(4'd0, 32'h8000_0000);
        @(negedge clk); #1; reg_addr = 4'd0;
        busy = 0;
        rd(4'd0, d);
        chk("R6 flag set after request", d & 32'h8000_0000, 32'h8000_0000);
        while (d[31] && busy < 40) begin
            busy++;
            rd(4'd0, d);
        end
        chk("R8 flag clears within bound", {31'b0, (busy <= 33)}, 32'h1);
        idle(extra);
    endtask

    task automatic set_field(input int f);
        wr(4'd1, 32'(f) << 8);
    endtask

    initial begin
        #(200_000 * 10);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int cnt;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 4'd0; reg_wdata = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        rd(4'd0, d); chk("R1 flag after reset", d, 32'h0);
        rd(4'd1, d); chk("R1 field after reset", d, 32'h0);
        cnt = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk); cnt += int'(clk_en);
        end
        chk("R1 full rate after reset", 32'(cnt), 32'd32);

        // R2 stray bits, unmapped address
        wr(4'd1, 32'hFFFF_F0FF);
        rd(4'd1, d); chk("R2 field only bits 12:8", d, 32'h0000_1000);
        rd(4'd7, d); chk("R2 unmapped reads 0", d, 32'h0);

        // R5 shadow has no effect without a request
        cnt = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk); cnt += int'(clk_en);
        end
        chk("R5 output unchanged before commit", 32'(cnt), 32'd64);

        // R9 write with bit 31 clear is ignored
        wr(4'd0, 32'h7FFF_FFFF);
        rd(4'd0, d); chk("R9 no request without bit 31", d, 32'h0);

        kick_and_wait(70);

        // sweep rates, requests at varied phases
        for (int k = 0; k < 6; k++) begin
            int f;
            case (k)
                0: f = 31;
                1: f = 1;
                2: f = 11;
                3: f = 5;
                4: f = 27;
                default: f = 0;
            endcase
            set_field(f);
            idle(3 * k + 1);
            kick_and_wait(40 + 7 * k);
        end

        // R9 rewrite and zero write while busy
        set_field(20);
        wr(4'd0, 32'h8000_0000);
        wr(4'd0, 32'h0);
        rd(4'd0, d); chk("R9 zero write does not cancel", d & 32'h8000_0000, 32'h8000_0000);
        wr(4'd0, 32'h8000_0000);
        idle(80);
        rd(4'd0, d); chk("R9 flag idle after single commit", d, 32'h0);

        idle(40);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule